// File: doc/BRIEF.md
# Wide-Word Beat Serializer

This block turns one wide data word into a short burst of narrow beats for a chip-to-chip bus. A slow producer presents a 216-bit word with a one-cycle valid strobe. The block copies the whole word into a bank of nine 24-bit holding registers in a single cycle. It then steps a beat index from 0 to 8 and drives one holding register onto the 24-bit output bus in each cycle. Every beat has an output valid, and the final beat also raises a last marker so that the far side can close the word.

Everything runs on one fast clock. The producer's rate is one ninth of the fast rate, so a new word is due at most once every nine fast cycles. A word that arrives in the same cycle as the final beat is taken at once, and its first beat follows with no idle cycle between the two bursts. A strobe that arrives earlier in a burst is dropped, and the block reports it on a one-cycle overrun flag.

Top module: `beat_serializer`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, `out_valid`, `out_last` and `overrun` are low. An `in_valid` seen during reset is not taken.
- R2: When `in_valid` is high at a clock edge and the block is idle, the whole of `in_data` is captured at that edge, and beat 0 of the word is on the bus in the cycle right after that edge.
- R3: Beat k of a captured word (k = 0 to 8) carries `in_data[24k+23:24k]` of that word. Beat 0 is the least significant slice.
- R4: `out_valid` is high for exactly nine consecutive cycles for each captured word, and low whenever no word is being sent.
- R5: `out_last` is high only on beat index 8, which is the ninth beat, and never while `out_valid` is low.
- R6: When `in_valid` is high during beats 0 to 7, the block does not take it: the remaining beats of the current word are unchanged and no new burst starts. `overrun` is then high for the single cycle that follows that edge.
- R7: When `in_valid` is high during beat 8, the block takes the new word. Its beat 0 follows in the next cycle, `out_valid` stays high across the boundary, and `overrun` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new wide word |
| in_data | input | 216 | Wide word from the producer |
| out_valid | output | 1 | A beat is on the bus |
| out_data | output | 24 | Current beat |
| out_last | output | 1 | Current beat is the last beat of the word |
| overrun | output | 1 | One-cycle flag: a strobe arrived mid-burst and was dropped |

## Verification
Two functions can fall in the same cycle: the final beat of one word, and the capture of the next word into the same holding registers that beat is still being read from. The bench provokes this by raising `in_valid` exactly on beat 8, both in directed bursts and in random ones. It then checks four things: the final beat still shows the old slice with `out_last` high, the next cycle shows the new word's beat 0 with `out_valid` unbroken, `out_last` is low on that beat, and `overrun` stays low. Mid-burst strobes at random beat positions are mixed in to check that a strobe on beat 8 is accepted and a strobe on any earlier beat is dropped and flagged.

// File: rtl/ser_pkg.sv
package ser_pkg;
   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_SEND = 1'b1
   } ser_state_e;
endpackage

// File: rtl/ser_beat_ctr.sv
module ser_beat_ctr #(
   parameter int NUM_BEATS = 9,
   localparam int CW = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   output logic          busy,
   output logic [CW-1:0] idx,
   output logic          at_last
);
   import ser_pkg::*;

   localparam logic [CW-1:0] LAST_IDX = CW'(NUM_BEATS - 1);

   ser_state_e st_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= SER_IDLE;
         idx  <= '0;
      end else if (start) begin
         st_q <= SER_SEND;
         idx  <= '0;
      end else if (st_q == SER_SEND) begin
         if (idx == LAST_IDX) begin
            st_q <= SER_IDLE;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign busy    = (st_q == SER_SEND);
   assign at_last = busy && (idx == LAST_IDX);

   // R4: an unfinished burst keeps going into the next cycle
   p_burst_continues_r4: assert property (@(posedge clk) disable iff (rst)
      (busy && !at_last && !start) |=> (busy && idx == $past(idx) + 1'b1));

   // R5: the index never runs past the final beat
   p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
      busy |-> (idx <= LAST_IDX));
endmodule

// File: rtl/ser_hold_bank.sv
module ser_hold_bank #(
   parameter int BEAT_W    = 24,
   parameter int NUM_BEATS = 9,
   localparam int WORD_W = BEAT_W * NUM_BEATS,
   localparam int CW     = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
   input  logic              clk,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic [CW-1:0]     sel,
   output logic [BEAT_W-1:0] beat_out
);
   logic [BEAT_W-1:0] slot_q [NUM_BEATS];

   for (genvar g = 0; g < NUM_BEATS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (load) slot_q[g] <= word_in[g*BEAT_W +: BEAT_W];
      end
   end

   always_comb begin
      beat_out = '0;
      for (int i = 0; i < NUM_BEATS; i++) begin
         if (sel == CW'(i)) beat_out = slot_q[i];
      end
   end
endmodule

// File: rtl/beat_serializer.sv
module beat_serializer #(
   parameter int BEAT_W    = 24,
   parameter int NUM_BEATS = 9,
   localparam int WORD_W = BEAT_W * NUM_BEATS,
   localparam int CW     = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   output logic [BEAT_W-1:0] out_data,
   output logic              out_last,
   output logic              overrun
);
   if (BEAT_W < 1) begin : g_bad_width
      $error("beat_serializer: BEAT_W must be at least 1");
   end
   if (NUM_BEATS < 2) begin : g_bad_count
      $error("beat_serializer: NUM_BEATS must be at least 2");
   end

   logic          busy;
   logic          at_last;
   logic [CW-1:0] idx;
   logic          accept;
   logic          ovr_q;

   assign accept = in_valid && (!busy || at_last);

   ser_beat_ctr #(.NUM_BEATS(NUM_BEATS)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .start   (accept),
      .busy    (busy),
      .idx     (idx),
      .at_last (at_last)
   );

   ser_hold_bank #(.BEAT_W(BEAT_W), .NUM_BEATS(NUM_BEATS)) u_bank (
      .clk      (clk),
      .load     (accept),
      .word_in  (in_data),
      .sel      (idx),
      .beat_out (out_data)
   );

   always_ff @(posedge clk) begin
      if (rst) ovr_q <= 1'b0;
      else     ovr_q <= in_valid && busy && !at_last;
   end

   assign out_valid = busy;
   assign out_last  = at_last;
   assign overrun   = ovr_q;

   // R2 / R7: an accepted strobe opens a burst at beat 0 in the next cycle
   p_accept_starts_r2: assert property (@(posedge clk) disable iff (rst)
      accept |=> (out_valid && idx == '0 && !out_last));

   // R5: the last marker only appears on a valid beat
   p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid);

   // R6: a dropped strobe neither restarts the index nor reloads
   p_drop_keeps_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && out_valid && !out_last) |=> (overrun && idx == $past(idx) + 1'b1));

   // R7: a strobe on the final beat is never flagged
   p_no_flag_on_last_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && out_last) |=> !overrun);
endmodule

// File: tb/sim_beat_serializer.sv
module sim_beat_serializer;
   localparam int BW = 24;
   localparam int NB = 9;
   localparam int WW = BW * NB;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [WW-1:0] in_data;
   logic          out_valid;
   logic [BW-1:0] out_data;
   logic          out_last;
   logic          overrun;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   beat_serializer u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .overrun(overrun)
   );

   function automatic logic [BW-1:0] exp_beat(input logic [WW-1:0] w, input int k);
      return w[k*BW +: BW];
   endfunction

   function automatic logic [WW-1:0] rand_word();
      logic [255:0] r;
      r = {$urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, $urandom};
      return r[WW-1:0];
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Sends one word and checks its nine beats. The word is already latched
   // when preloaded is set. ovr_beat: beat 0..7 with a stray strobe, or -1.
   // chain: offer nxt on beat 8.
   task automatic send(input logic [WW-1:0] w, input int ovr_beat,
                       input bit chain, input logic [WW-1:0] nxt,
                       input bit preloaded);
      if (!preloaded) begin
         in_valid = 1'b1;
         in_data  = w;
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = rand_word();
      end
      for (int k = 0; k < NB; k++) begin
         chk("R4", "out_valid in burst", WW'(out_valid), WW'(1));
         chk("R3", "beat data", WW'(out_data), WW'(exp_beat(w, k)));
         chk("R5", "out_last", WW'(out_last), WW'(k == NB - 1));
         if (k > 0)
            chk("R6", "overrun flag", WW'(overrun), WW'(k - 1 == ovr_beat));
         else if (preloaded)
            chk("R7", "no overrun after chained accept", WW'(overrun), WW'(0));
         if (k == ovr_beat) begin
            in_valid = 1'b1;
            in_data  = rand_word();
         end
         if (k == NB - 1 && chain) begin
            in_valid = 1'b1;
            in_data  = nxt;
         end
         @(negedge clk);
         in_valid = 1'b0;
      end
      if (!chain) begin
         chk("R4", "out_valid idle after burst", WW'(out_valid), WW'(0));
         chk("R5", "out_last idle", WW'(out_last), WW'(0));
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [WW-1:0] cur;
      logic [WW-1:0] nx;
      bit            pend;
      void'($urandom(32'd20240611));
      rst = 1'b1;
      in_valid = 1'b0;
      in_data = '0;
      @(negedge clk);
      in_valid = 1'b1;
      in_data = {NB{24'hABCDEF}};
      @(negedge clk);
      chk("R1", "out_valid in reset", WW'(out_valid), WW'(0));
      chk("R1", "out_last in reset", WW'(out_last), WW'(0));
      chk("R1", "overrun in reset", WW'(overrun), WW'(0));
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "out_valid after reset", WW'(out_valid), WW'(0));
      chk("R1", "overrun after reset", WW'(overrun), WW'(0));

      // Directed: beat slices distinguishable by index
      cur = '0;
      for (int k = 0; k < NB; k++) cur[k*BW +: BW] = BW'(24'h100000 * (k + 1) + k);
      send(cur, -1, 0, '0, 0);                                 // R2 R3
      @(negedge clk);
      send({NB{24'hFFFFFF}}, -1, 0, '0, 0);
      send({NB{24'hAAAAAA}}, 0, 0, '0, 0);                     // R6 at beat 0
      send({NB{24'h555555}}, 7, 0, '0, 0);                     // R6 at beat 7
      // Directed: back-to-back capture on the final beat
      send({NB{24'hCCCCCC}}, -1, 1, {NB{24'h333333}}, 0);      // R7
      send({NB{24'h333333}}, 3, 0, '0, 1);

      // Constrained random
      pend = 0;
      nx = '0;
      cur = rand_word();
      for (int n = 0; n < 60; n++) begin
         int  ob;
         bit  ch;
         logic [WW-1:0] nw;
         ob = (($urandom % 3) == 0) ? int'($urandom % 8) : -1;
         ch = (($urandom % 3) == 0);
         nw = rand_word();
         send(cur, ob, ch, nw, pend);
         pend = ch;
         cur  = ch ? nw : rand_word();
         if (!ch) repeat ($urandom % 4) @(negedge clk);
      end
      if (pend) send(cur, -1, 0, '0, 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule